// File: doc/BRIEF.md
# Adjustable PTP Time Counter

This block keeps a free-running nanosecond time base for precision time protocol logic. On every enabled clock the count grows by a small programmable step. A second step value stands ready for fine frequency trimming. A correction scheduler swaps that second step in once per programmable number of clocks. This lets software make the clock run slightly fast or slow without changing the nominal step. The count can wrap at a programmable period, which gives a time base shorter than the full counter width. Each wrap raises a one-cycle pulse toward compare channels, and a control bit can gate a second copy of that pulse.

A simple valid/write/address/data bus configures the block. Reads return registered data one cycle after the request. The live count goes out on a port for compare logic. Software does not read it directly. Software first issues a capture command, which freezes a copy in a readable register. Writing that same register sets the time. A restart command clears the count.

The correction scheduler is a three-state machine:

- **CS_OFF**: correction is disabled.
- **CS_WAIT**: the machine counts nominal steps.
- **CS_CORR**: the next enabled step uses the correction increment.

Its transitions are:

- **reinit**: any state goes to CS_WAIT with the step count at zero. This happens on a write of the correction period or on a restart.
- **disable**: CS_WAIT or CS_CORR goes to CS_OFF when the correction period is zero.
- **arm**: CS_WAIT goes to CS_CORR on the enabled step that completes N nominal steps.
- **apply**: CS_CORR goes back to CS_WAIT, with the step count at zero, on the next enabled step.

Top module: `ptp_time_counter`

## Requirements
- R1: After reset the following are all zero: `live_count`, `wrap_pulse`, `wrap_evt`, `bus_rdata` and every readable register.
- R2: Control bit 0 enables counting. While it is 0, the count holds its value except for a restart or a direct load.
- R3: On each enabled clock that is not a correction step, the count advances by the nominal increment held in bits [6:0] of the increment register (offset 0x14).
- R4: Let N be the value of the correction period register (offset 0x10). When N is nonzero, the correction increment in bits [14:8] of the increment register replaces the nominal one on every (N+1)-th enabled step. Counting restarts after a write of that register or a restart. When N is zero, correction never applies.
- R5: Period reset is on when control field [5:4] is nonzero and the period register (offset 0x0C) is nonzero. When it is on and count plus increment reaches or exceeds the period, the new count is that sum minus the period. Otherwise the sum is used as it is.
- R6: `wrap_pulse` is high for exactly the one cycle in which the wrapped count first appears on `live_count`.
- R7: `wrap_evt` pulses together with `wrap_pulse` only when control bit 7 is set. Otherwise it stays low.
- R8: Writing control bit 9 as 1 sets the count to zero on that clock edge. This takes precedence over counting and loading. Bit 9 always reads back as 0.
- R9: Writing control bit 11 as 1 copies the count present during the write cycle into the value register (offset 0x04). A read of that register returns the copy while the live count keeps running. Bit 11 always reads back as 0.
- R10: A write to the value register (offset 0x04) loads the written data into the count on that edge. This takes precedence over counting.
- R11: Readback works as follows:
  - Control returns bits 0, 4, 5, 7 and 13 as written.
  - The increment register returns only bits [14:8] and [6:0].
  - The period and correction period registers return all 32 bits.
  - Offset 0x08 and unmapped offsets read 0.
  - Read data appears the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| live_count | output | 32 | Current time count for compare channels |
| wrap_pulse | output | 1 | One-cycle pulse on each period wrap |
| wrap_evt | output | 1 | Wrap pulse gated by control bit 7 |

## Verification
The bench builds the block with its default parameters: a 32-bit count, 7-bit increments and 8-bit offsets. Because the period is a register, the bench programs a period of 100 with a step of 30. This brings wraps, including wrap remainders that are not zero, within a handful of cycles. The bench also uses the widest step of 127 and correction periods of 1 and 3. These expose the first correction step, back-to-back alternation and a correction increment of zero, all within a few dozen clocks.

// File: rtl/ptp_tc_pkg.sv
package ptp_tc_pkg;

    // byte offsets
    localparam int unsigned OFS_CTRL   = 'h00;
    localparam int unsigned OFS_VALUE  = 'h04;
    localparam int unsigned OFS_RSVD   = 'h08;
    localparam int unsigned OFS_PERIOD = 'h0C;
    localparam int unsigned OFS_CORR   = 'h10;
    localparam int unsigned OFS_INC    = 'h14;

    // control bit positions
    localparam int unsigned B_EN      = 0;
    localparam int unsigned B_PR_LO   = 4;
    localparam int unsigned B_EVT     = 7;
    localparam int unsigned B_RESTART = 9;
    localparam int unsigned B_CAPTURE = 11;
    localparam int unsigned B_SLAVE   = 13;

    // lsb of the correction step inside the increment register
    localparam int unsigned COR_LSB = 8;

    typedef enum logic [1:0] {
        CS_OFF  = 2'd0,
        CS_WAIT = 2'd1,
        CS_CORR = 2'd2
    } corr_state_t;

    typedef struct packed {
        logic       slave;
        logic       evt_en;
        logic [1:0] prd;
        logic       en;
    } ctrl_t;

endpackage

// File: rtl/ptp_tc_regs.sv
module ptp_tc_regs
    import ptp_tc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned INC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cap_value,
    output logic              ctrl_en,
    output logic [1:0]        ctrl_pr,
    output logic              ctrl_evt,
    output logic [INC_W-1:0]  inc_nom,
    output logic [INC_W-1:0]  inc_cor,
    output logic [CNT_W-1:0]  corr_n,
    output logic [CNT_W-1:0]  period,
    output logic              restart_stb,
    output logic              capture_stb,
    output logic              load_stb,
    output logic              corr_wr_stb,
    output logic [CNT_W-1:0]  load_val
);

    ctrl_t             ctrl_q;
    logic              wr_en;
    logic              rd_en;
    logic              hit_ctrl;
    logic              hit_value;
    logic              hit_period;
    logic              hit_corr;
    logic              hit_inc;
    logic [DATA_W-1:0] rd_mux;

    assign wr_en      = bus_valid & bus_write;
    assign rd_en      = bus_valid & ~bus_write;
    assign hit_ctrl   = (bus_addr == ADDR_W'(OFS_CTRL));
    assign hit_value  = (bus_addr == ADDR_W'(OFS_VALUE));
    assign hit_period = (bus_addr == ADDR_W'(OFS_PERIOD));
    assign hit_corr   = (bus_addr == ADDR_W'(OFS_CORR));
    assign hit_inc    = (bus_addr == ADDR_W'(OFS_INC));

    // command strobes act on the same edge as the write
    assign restart_stb = wr_en & hit_ctrl & bus_wdata[B_RESTART];
    assign capture_stb = wr_en & hit_ctrl & bus_wdata[B_CAPTURE];
    assign load_stb    = wr_en & hit_value;
    assign corr_wr_stb = wr_en & hit_corr;
    assign load_val    = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            inc_nom <= '0;
            inc_cor <= '0;
            corr_n  <= '0;
            period  <= '0;
        end else if (wr_en) begin
            if (hit_ctrl) begin
                ctrl_q.en     <= bus_wdata[B_EN];
                ctrl_q.prd    <= bus_wdata[B_PR_LO +: 2];
                ctrl_q.evt_en <= bus_wdata[B_EVT];
                ctrl_q.slave  <= bus_wdata[B_SLAVE];
            end
            if (hit_inc) begin
                inc_nom <= bus_wdata[INC_W-1:0];
                inc_cor <= bus_wdata[COR_LSB +: INC_W];
            end
            if (hit_corr) begin
                corr_n <= bus_wdata[CNT_W-1:0];
            end
            if (hit_period) begin
                period <= bus_wdata[CNT_W-1:0];
            end
        end
    end

    assign ctrl_en  = ctrl_q.en;
    assign ctrl_pr  = ctrl_q.prd;
    assign ctrl_evt = ctrl_q.evt_en;

    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            ADDR_W'(OFS_CTRL): begin
                rd_mux[B_EN]          = ctrl_q.en;
                rd_mux[B_PR_LO +: 2]  = ctrl_q.prd;
                rd_mux[B_EVT]         = ctrl_q.evt_en;
                rd_mux[B_SLAVE]       = ctrl_q.slave;
            end
            ADDR_W'(OFS_VALUE):  rd_mux[CNT_W-1:0] = cap_value;
            ADDR_W'(OFS_PERIOD): rd_mux[CNT_W-1:0] = period;
            ADDR_W'(OFS_CORR):   rd_mux[CNT_W-1:0] = corr_n;
            ADDR_W'(OFS_INC): begin
                rd_mux[INC_W-1:0]        = inc_nom;
                rd_mux[COR_LSB +: INC_W] = inc_cor;
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (rd_en) begin
            bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/ptp_tc_corr_sched.sv
module ptp_tc_corr_sched
    import ptp_tc_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             reinit,
    input  logic [CNT_W-1:0] corr_n,
    output logic             use_corr
);

    corr_state_t      state_q;
    corr_state_t      state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             last_nom;

    assign last_nom = (cnt_q == corr_n - 1'b1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CS_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (reinit) begin
            state_d = CS_WAIT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                CS_OFF: begin
                    state_d = CS_OFF;
                end
                CS_WAIT: begin
                    if (corr_n == '0) begin
                        state_d = CS_OFF;
                    end else if (step) begin
                        if (last_nom) begin
                            state_d = CS_CORR;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                CS_CORR: begin
                    if (corr_n == '0) begin
                        state_d = CS_OFF;
                    end else if (step) begin
                        state_d = CS_WAIT;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = CS_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        use_corr = (state_q == CS_CORR);
    end

endmodule

// File: rtl/ptp_tc_counter.sv
module ptp_tc_counter #(
    parameter int unsigned CNT_W = 32,
    parameter int unsigned INC_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pr_on,
    input  logic             evt_en,
    input  logic             restart,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             capture,
    input  logic             use_corr,
    input  logic [INC_W-1:0] inc_nom,
    input  logic [INC_W-1:0] inc_cor,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_value,
    output logic             wrap_pulse,
    output logic             wrap_evt
);

    localparam int unsigned SUM_W = CNT_W + 1;

    logic [INC_W-1:0] inc_sel;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] period_x;
    logic             wrap_cond;
    logic             advance;
    logic [CNT_W-1:0] next_val;

    assign inc_sel   = use_corr ? inc_cor : inc_nom;
    assign sum       = {1'b0, count} + SUM_W'(inc_sel);
    assign period_x  = {1'b0, period};
    assign wrap_cond = pr_on && (period != '0) && (sum >= period_x);
    assign next_val  = wrap_cond ? CNT_W'(sum - period_x) : sum[CNT_W-1:0];
    assign advance   = en & ~restart & ~load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (en) begin
            count <= next_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_value  <= '0;
            wrap_pulse <= 1'b0;
            wrap_evt   <= 1'b0;
        end else begin
            if (capture) begin
                cap_value <= count;
            end
            wrap_pulse <= advance & wrap_cond;
            wrap_evt   <= advance & wrap_cond & evt_en;
        end
    end

endmodule

// File: rtl/ptp_time_counter.sv
module ptp_time_counter #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned INC_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [CNT_W-1:0]  live_count,
    output logic              wrap_pulse,
    output logic              wrap_evt
);

    logic             ctrl_en;
    logic [1:0]       ctrl_pr;
    logic             ctrl_evt;
    logic [INC_W-1:0] inc_nom;
    logic [INC_W-1:0] inc_cor;
    logic [CNT_W-1:0] corr_n;
    logic [CNT_W-1:0] period;
    logic             restart_stb;
    logic             capture_stb;
    logic             load_stb;
    logic             corr_wr_stb;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cap_value;
    logic             use_corr;
    logic             sched_step;

    assign sched_step = ctrl_en & ~restart_stb & ~load_stb;

    ptp_tc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .INC_W  (INC_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_valid   (bus_valid),
        .bus_write   (bus_write),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .cap_value   (cap_value),
        .ctrl_en     (ctrl_en),
        .ctrl_pr     (ctrl_pr),
        .ctrl_evt    (ctrl_evt),
        .inc_nom     (inc_nom),
        .inc_cor     (inc_cor),
        .corr_n      (corr_n),
        .period      (period),
        .restart_stb (restart_stb),
        .capture_stb (capture_stb),
        .load_stb    (load_stb),
        .corr_wr_stb (corr_wr_stb),
        .load_val    (load_val)
    );

    ptp_tc_corr_sched #(
        .CNT_W (CNT_W)
    ) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (sched_step),
        .reinit   (restart_stb | corr_wr_stb),
        .corr_n   (corr_n),
        .use_corr (use_corr)
    );

    ptp_tc_counter #(
        .CNT_W (CNT_W),
        .INC_W (INC_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (ctrl_en),
        .pr_on      (ctrl_pr != 2'b00),
        .evt_en     (ctrl_evt),
        .restart    (restart_stb),
        .load       (load_stb),
        .load_val   (load_val),
        .capture    (capture_stb),
        .use_corr   (use_corr),
        .inc_nom    (inc_nom),
        .inc_cor    (inc_cor),
        .period     (period),
        .count      (live_count),
        .cap_value  (cap_value),
        .wrap_pulse (wrap_pulse),
        .wrap_evt   (wrap_evt)
    );

endmodule

// File: rtl/ptp_tc_chk.sv
module ptp_tc_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned INC_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [CNT_W-1:0]  live_count,
    input logic              wrap_pulse,
    input logic              wrap_evt,
    input logic              ctrl_en,
    input logic [1:0]        ctrl_pr,
    input logic              use_corr,
    input logic [INC_W-1:0]  inc_nom,
    input logic              restart_stb,
    input logic              load_stb
);

    logic [CNT_W-1:0] nom_next;
    assign nom_next = live_count + CNT_W'(inc_nom);

    // R2
    frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !restart_stb && !load_stb) |=> $stable(live_count));

    // R3
    nominal_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && !restart_stb && !load_stb && !use_corr && ctrl_pr == 2'b00)
        |=> live_count == $past(nom_next));

    // R6
    wrap_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |-> $past(ctrl_pr != 2'b00));

    // R7
    evt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |-> wrap_pulse);

    // R8
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_stb |=> live_count == '0);

    // R10
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !restart_stb) |=> live_count == $past(CNT_W'(bus_wdata)));

    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_valid && !bus_write) |=> $stable(bus_rdata));

endmodule

bind ptp_time_counter ptp_tc_chk #(
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W),
    .INC_W  (INC_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .live_count  (live_count),
    .wrap_pulse  (wrap_pulse),
    .wrap_evt    (wrap_evt),
    .ctrl_en     (ctrl_en),
    .ctrl_pr     (ctrl_pr),
    .use_corr    (use_corr),
    .inc_nom     (inc_nom),
    .restart_stb (restart_stb),
    .load_stb    (load_stb)
);

// File: tb/ptp_time_counter_tb.sv
module ptp_time_counter_tb;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_VALUE  = 8'h04;
    localparam logic [7:0] A_RSVD   = 8'h08;
    localparam logic [7:0] A_PERIOD = 8'h0C;
    localparam logic [7:0] A_CORR   = 8'h10;
    localparam logic [7:0] A_INC    = 8'h14;

    // nominal step, correction step, correction period N, steps, expected count
    localparam logic [31:0] VEC [0:3][0:4] = '{
        '{32'd8,   32'd9, 32'd0, 32'd10, 32'd80},
        '{32'd8,   32'd9, 32'd3, 32'd10, 32'd82},
        '{32'd5,   32'd3, 32'd1, 32'd7,  32'd29},
        '{32'd127, 32'd0, 32'd2, 32'd6,  32'd508}
    };

    logic        clk;
    logic        rst_n;
    logic        bus_valid;
    logic        bus_write;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] live_count;
    logic        wrap_pulse;
    logic        wrap_evt;

    int checks;
    int errors;
    bit done;

    ptp_time_counter u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_valid  (bus_valid),
        .bus_write  (bus_write),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .live_count (live_count),
        .wrap_pulse (wrap_pulse),
        .wrap_evt   (wrap_evt)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0;
        bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1;
        bus_write = 1'b0;
        bus_addr  = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        checks = 0;
        errors = 0;
        done = 1'b0;
        rst_n = 1'b0;
        bus_valid = 1'b0;
        bus_write = 1'b0;
        bus_addr = '0;
        bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 live_count", live_count, 32'd0);
        check("R1 wrap_pulse", {31'd0, wrap_pulse}, 32'd0);
        check("R1 wrap_evt", {31'd0, wrap_evt}, 32'd0);
        check("R1 bus_rdata", bus_rdata, 32'd0);
        bus_rd(A_CTRL, rd);
        check("R1 ctrl", rd, 32'd0);
        bus_rd(A_INC, rd);
        check("R1 inc", rd, 32'd0);

        // R3 R4 vector table
        for (int i = 0; i < 4; i++) begin
            bus_wr(A_CTRL, 32'h200);
            bus_wr(A_INC, (VEC[i][1] << 8) | VEC[i][0]);
            bus_wr(A_CORR, VEC[i][2]);
            bus_wr(A_CTRL, 32'h1);
            repeat (VEC[i][3]) @(negedge clk);
            check($sformatf("R3 R4 vector %0d", i), live_count, VEC[i][4]);
            bus_wr(A_CTRL, 32'h0);
        end

        // R9 capture while running
        bus_wr(A_CTRL, 32'h200);
        bus_wr(A_INC, 32'd4);
        bus_wr(A_CORR, 32'd0);
        bus_wr(A_CTRL, 32'h1);
        repeat (3) @(negedge clk);
        check("R3 running count", live_count, 32'd12);
        bus_wr(A_CTRL, 32'h801);
        check("R9 live after capture", live_count, 32'd16);
        bus_rd(A_VALUE, rd);
        check("R9 captured value", rd, 32'd12);
        bus_rd(A_CTRL, rd);
        check("R9 capture bit reads 0", rd, 32'h1);

        // R8 restart while running
        bus_wr(A_CTRL, 32'h201);
        check("R8 restart to zero", live_count, 32'd0);
        @(negedge clk);
        check("R8 counts after restart", live_count, 32'd4);

        // R10 load while running
        bus_wr(A_VALUE, 32'h1234);
        check("R10 load", live_count, 32'h1234);
        @(negedge clk);
        check("R10 counts from load", live_count, 32'h1238);

        // R2 freeze
        bus_wr(A_CTRL, 32'h0);
        repeat (5) @(negedge clk);
        check("R2 frozen", live_count, 32'h123C);

        // R5 R6 R7 period wrap
        bus_wr(A_CTRL, 32'h200);
        bus_wr(A_INC, 32'd30);
        bus_wr(A_PERIOD, 32'd100);
        bus_wr(A_CTRL, 32'h31);
        repeat (4) @(negedge clk);
        check("R5 wrap remainder", live_count, 32'd20);
        check("R6 wrap pulse high", {31'd0, wrap_pulse}, 32'd1);
        check("R7 event gated off", {31'd0, wrap_evt}, 32'd0);
        @(negedge clk);
        check("R6 wrap pulse one cycle", {31'd0, wrap_pulse}, 32'd0);
        bus_wr(A_CTRL, 32'hB1);
        check("R5 before wrap", live_count, 32'd80);
        @(negedge clk);
        check("R5 second wrap", live_count, 32'd10);
        check("R7 event on wrap", {31'd0, wrap_evt}, 32'd1);
        @(negedge clk);
        check("R7 event one cycle", {31'd0, wrap_evt}, 32'd0);

        // R5 period reset off
        bus_wr(A_CTRL, 32'h201);
        repeat (4) @(negedge clk);
        check("R5 no wrap when off", live_count, 32'd120);
        check("R6 no pulse when off", {31'd0, wrap_pulse}, 32'd0);

        // R11 readback
        bus_wr(A_CTRL, 32'h2AB0);
        bus_rd(A_CTRL, rd);
        check("R11 ctrl readback", rd, 32'h20B0);
        bus_wr(A_INC, 32'hFFFF_FFFF);
        bus_rd(A_INC, rd);
        check("R11 inc readback", rd, 32'h7F7F);
        bus_rd(A_PERIOD, rd);
        check("R11 period readback", rd, 32'd100);
        bus_wr(A_CORR, 32'h8000_0005);
        bus_rd(A_CORR, rd);
        check("R11 corr readback", rd, 32'h8000_0005);
        bus_wr(A_RSVD, 32'hDEAD);
        bus_rd(A_RSVD, rd);
        check("R11 reserved reads 0", rd, 32'd0);
        bus_rd(8'h18, rd);
        check("R11 unmapped reads 0", rd, 32'd0);
        repeat (2) @(negedge clk);
        check("R11 rdata held", bus_rdata, 32'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule